// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block sits at the front of a small processor pipeline. It receives an instruction as a stream of bytes, most significant byte first. The first two bytes form a 16-bit instruction word. Depending on the opcode, four more bytes may follow and form a 32-bit extension word. Once the last byte of an instruction is accepted, the block presents a registered set of decode fields for one cycle:

- a format tag,
- the opcode,
- up to two register indices,
- a 16-bit immediate,
- the total length in bytes,
- the extension word,
- an illegal-encoding flag.

The two top bits of the instruction word select one of three unequal layouts:

- Branch form: a 4-bit condition opcode and a 10-bit signed halfword offset.
- Register-immediate form: a 2-bit opcode, one register and an 8-bit unsigned constant.
- Two-register form: an 8-bit opcode and two registers.

Only a fixed subset of two-register opcodes carries the trailing 32-bit word. The block therefore decides at the second byte whether the instruction is complete or must keep collecting. Execution, register storage and memory live elsewhere.

Top module: `tri_fmt_decoder`

## Requirements
- R1: After reset, `dec_vld` is 0 and every decode output is 0 until the first instruction completes.
- R2: Bytes are assembled most significant first: the first accepted byte is instruction bits [15:8], the second is bits [7:0], and for a 6-byte instruction the third to sixth bytes become extension bits [31:24], [23:16], [15:8], [7:0].
- R3: `dec_fmt` is 0 when word bit 15 is 0 (two-register form), 1 when bits [15:14] are 2'b10 (register-immediate form), and 2 when bits [15:14] are 2'b11 (branch form).
- R4: Two-register form: `dec_op` = bits [15:8], `dec_ra` = bits [7:4], `dec_rb` = bits [3:0], `dec_imm` = 0.
- R5: Register-immediate form: `dec_op` = bits [13:12] zero-extended, `dec_ra` = bits [11:8], `dec_imm` = bits [7:0] zero-extended, `dec_rb` = 0. The opcode values are 0 add, 1 subtract, 2 read special register, 3 write special register. All four are legal.
- R6: Branch form: `dec_op` = bits [13:10] zero-extended, `dec_imm` = bits [9:0] sign-extended and multiplied by two (a byte offset), `dec_ra` = `dec_rb` = 0.
- R7: The following two-register opcodes give `dec_len` = 6 and carry the assembled extension on `dec_ext`: 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 (software interrupt) and 0x36 to 0x39. Every other instruction gives `dec_len` = 2 and `dec_ext` = 0.
- R8: `dec_bad` is 1 for these encodings, each of which has length 2:
  - two-register opcode 0x00;
  - two-register opcodes 0x16, 0x17 and 0x18;
  - any two-register opcode above 0x39;
  - branch opcodes 10 to 15.
  It is 0 for every other encoding.
- R9: `dec_vld` is high for exactly one cycle, in the cycle after the edge that accepts the last byte of an instruction. Cycles with `byte_vld` low neither advance nor reset the byte position.
- R10: While `dec_vld` is low, all decode outputs hold the values of the most recent pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A byte is presented on `byte_in` this cycle |
| byte_in | input | 8 | Instruction stream byte |
| dec_vld | output | 1 | One-cycle pulse: decode fields are new |
| dec_fmt | output | 2 | Format tag (0 two-register, 1 register-immediate, 2 branch) |
| dec_op | output | 8 | Opcode, zero-extended |
| dec_ra | output | 4 | First register index |
| dec_rb | output | 4 | Second register index |
| dec_imm | output | 16 | Immediate or branch byte offset |
| dec_len | output | 3 | Instruction length in bytes (2 or 6) |
| dec_ext | output | 32 | Extension word, 0 for 2-byte instructions |
| dec_bad | output | 1 | Illegal encoding |

## Verification
A byte position counter that slips by one makes the next pulse appear a cycle early or late, or never. After that, every later instruction is assembled out of alignment. As a result, the fields seen at the very next pulse already mismatch and the errors never self-correct. A fault in the stored instruction word during extension collection shows only in 6-byte instructions, as wrong fields at their pulse, four accepted bytes after the word was formed. The scoreboard compares every pulse against an independent model and the cycle in which it was due. Between pulses, it also checks that the outputs hold.

// File: rtl/tfd_pkg.sv
`timescale 1ns/1ps
package tfd_pkg;
  parameter int BYTE_W     = 8;
  parameter int WORD_BYTES = 2;
  parameter int EXT_BYTES  = 4;

  localparam int WORD_W    = BYTE_W * WORD_BYTES;
  localparam int EXT_W     = BYTE_W * EXT_BYTES;
  localparam int TOT_BYTES = WORD_BYTES + EXT_BYTES;
  localparam int CNT_W     = $clog2(TOT_BYTES);
  localparam int LEN_W     = $clog2(TOT_BYTES + 1);
  localparam int OP_W      = 8;
  localparam int REG_W     = 4;
  localparam int IMM_W     = 16;
  localparam int OFS_W     = 10;
  localparam int COND_W    = 4;

  localparam logic [OP_W-1:0]   PAIR_LAST    = 8'h39;
  localparam logic [OP_W-1:0]   GAP_LO       = 8'h16;
  localparam logic [OP_W-1:0]   GAP_HI       = 8'h18;
  localparam logic [COND_W-1:0] COND_LAST    = 4'd9;

  typedef enum logic [1:0] {
    FMT_PAIR   = 2'd0,
    FMT_RIMM   = 2'd1,
    FMT_BRANCH = 2'd2
  } fmt_e;

  typedef struct packed {
    fmt_e              fmt;
    logic [OP_W-1:0]   op;
    logic [REG_W-1:0]  ra;
    logic [REG_W-1:0]  rb;
    logic [IMM_W-1:0]  imm;
    logic              bad;
    logic              long_f;
  } dec_t;

  // Signed halfword offset turned into a byte offset.
  function automatic logic [IMM_W-1:0] branch_ofs(input logic [OFS_W-1:0] f);
    return {{(IMM_W-OFS_W-1){f[OFS_W-1]}}, f, 1'b0};
  endfunction

  function automatic logic pair_legal(input logic [OP_W-1:0] op);
    return (op != '0) && (op <= PAIR_LAST) && !((op >= GAP_LO) && (op <= GAP_HI));
  endfunction

  // Opcodes followed by a 32-bit extension word.
  function automatic logic pair_long(input logic [OP_W-1:0] op);
    case (op)
      8'h01, 8'h03, 8'h08, 8'h09, 8'h0c, 8'h0d,
      8'h1a, 8'h1b, 8'h1d, 8'h1f, 8'h20, 8'h22,
      8'h24, 8'h30, 8'h36, 8'h37, 8'h38, 8'h39: return 1'b1;
      default:                                   return 1'b0;
    endcase
  endfunction

  function automatic logic branch_legal(input logic [COND_W-1:0] c);
    return c <= COND_LAST;
  endfunction
endpackage

// File: rtl/tfd_fields.sv
`timescale 1ns/1ps
module tfd_fields
  import tfd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  logic pair_sel;
  logic branch_sel;

  assign pair_sel   = !word[WORD_W-1];
  assign branch_sel = word[WORD_W-1] && word[WORD_W-2];

  always_comb begin
    dec = '0;
    if (pair_sel) begin
      dec.fmt    = FMT_PAIR;
      dec.op     = word[15:8];
      dec.ra     = word[7:4];
      dec.rb     = word[3:0];
      dec.bad    = !pair_legal(word[15:8]);
      dec.long_f = pair_long(word[15:8]);
    end else if (branch_sel) begin
      dec.fmt    = FMT_BRANCH;
      dec.op     = OP_W'(word[13:10]);
      dec.imm    = branch_ofs(word[OFS_W-1:0]);
      dec.bad    = !branch_legal(word[13:10]);
    end else begin
      dec.fmt    = FMT_RIMM;
      dec.op     = OP_W'(word[13:12]);
      dec.ra     = word[11:8];
      dec.imm    = IMM_W'(word[7:0]);
    end
  end
endmodule

// File: rtl/tfd_gather.sv
`timescale 1ns/1ps
module tfd_gather
  import tfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              need_ext,
  output logic [WORD_W-1:0] word_now,
  output logic [EXT_W-1:0]  ext_now,
  output logic              fire
);
  localparam logic [CNT_W-1:0] WORD_END = CNT_W'(WORD_BYTES - 1);
  localparam logic [CNT_W-1:0] ALL_END  = CNT_W'(TOT_BYTES - 1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] word_sr;
  logic [EXT_W-1:0]  ext_sr;
  logic              at_word_end;
  logic              in_word;

  assign at_word_end = (cnt == WORD_END);
  assign in_word     = (cnt <= WORD_END);
  assign word_now    = at_word_end ? {word_sr[WORD_W-BYTE_W-1:0], byte_in} : word_sr;
  assign ext_now     = {ext_sr[EXT_W-BYTE_W-1:0], byte_in};
  assign fire        = byte_vld && ((at_word_end && !need_ext) || (cnt == ALL_END));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      word_sr <= '0;
      ext_sr  <= '0;
    end else if (byte_vld) begin
      if (in_word) word_sr <= {word_sr[WORD_W-BYTE_W-1:0], byte_in};
      else         ext_sr  <= {ext_sr[EXT_W-BYTE_W-1:0], byte_in};
      cnt <= fire ? '0 : cnt + 1'b1;
    end
  end

  // R9: an idle cycle leaves the byte position alone
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(cnt));
  // R9: position never runs past the longest instruction
  p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ALL_END);
  // R7: completion at the word boundary only for short instructions
  p_short_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && at_word_end) |-> !need_ext);
endmodule

// File: rtl/tri_fmt_decoder.sv
`timescale 1ns/1ps
module tri_fmt_decoder
  import tfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  output logic              dec_vld,
  output logic [1:0]        dec_fmt,
  output logic [7:0]        dec_op,
  output logic [3:0]        dec_ra,
  output logic [3:0]        dec_rb,
  output logic [15:0]       dec_imm,
  output logic [2:0]        dec_len,
  output logic [31:0]       dec_ext,
  output logic              dec_bad
);
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(WORD_BYTES);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(TOT_BYTES);

  logic [WORD_W-1:0] word_now;
  logic [EXT_W-1:0]  ext_now;
  logic              fire;
  dec_t              dec_now;

  dec_t              out_q;
  logic              vld_q;
  logic [LEN_W-1:0]  len_q;
  logic [EXT_W-1:0]  ext_q;

  tfd_gather u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .need_ext (dec_now.long_f),
    .word_now (word_now),
    .ext_now  (ext_now),
    .fire     (fire)
  );

  tfd_fields u_fields (
    .word (word_now),
    .dec  (dec_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      out_q <= '0;
      len_q <= '0;
      ext_q <= '0;
    end else begin
      vld_q <= fire;
      if (fire) begin
        out_q <= dec_now;
        len_q <= dec_now.long_f ? LEN_LONG : LEN_SHORT;
        ext_q <= dec_now.long_f ? ext_now : '0;
      end
    end
  end

  assign dec_vld = vld_q;
  assign dec_fmt = out_q.fmt;
  assign dec_op  = out_q.op;
  assign dec_ra  = out_q.ra;
  assign dec_rb  = out_q.rb;
  assign dec_imm = out_q.imm;
  assign dec_len = len_q;
  assign dec_ext = ext_q;
  assign dec_bad = out_q.bad;

  // R9: single-cycle pulse
  p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);
  // R9: a pulse always follows an accepted byte
  p_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(byte_vld));
  // R7: only two legal lengths
  p_len_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> (dec_len == LEN_SHORT || dec_len == LEN_LONG));
  // R7: short instructions carry no extension
  p_short_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_len == LEN_SHORT) |-> (dec_ext == '0));
  // R8: illegal encodings are short
  p_bad_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_bad) |-> (dec_len == LEN_SHORT));
  // R6: branch form names no registers
  p_branch_regs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_fmt == FMT_BRANCH) |-> (dec_ra == '0 && dec_rb == '0));
  // R10: outputs hold between pulses
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> ($stable(dec_op) && $stable(dec_ext) && $stable(dec_imm)
                  && $stable(dec_len) && $stable(dec_bad)));
endmodule

// File: tb/tri_fmt_decoder_tb_top.sv
`timescale 1ns/1ps
module tri_fmt_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        dec_vld;
  logic [1:0]  dec_fmt;
  logic [7:0]  dec_op;
  logic [3:0]  dec_ra;
  logic [3:0]  dec_rb;
  logic [15:0] dec_imm;
  logic [2:0]  dec_len;
  logic [31:0] dec_ext;
  logic        dec_bad;

  tri_fmt_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .dec_vld(dec_vld), .dec_fmt(dec_fmt), .dec_op(dec_op), .dec_ra(dec_ra),
    .dec_rb(dec_rb), .dec_imm(dec_imm), .dec_len(dec_len), .dec_ext(dec_ext),
    .dec_bad(dec_bad)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [1:0]  fmt;
    logic [7:0]  op;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [15:0] imm;
    logic [2:0]  len;
    logic [31:0] ext;
    logic        bad;
    int          due;
  } exp_t;

  localparam logic [7:0] LONG_OPS [18] = '{
    8'h39, 8'h38, 8'h37, 8'h36, 8'h30, 8'h24, 8'h22, 8'h20, 8'h1f,
    8'h1d, 8'h1b, 8'h1a, 8'h0d, 8'h0c, 8'h09, 8'h08, 8'h03, 8'h01};

  exp_t q[$];
  exp_t last;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   run = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [15:0] w, input logic [31:0] x);
    exp_t e;
    bit   legal;
    bit   long_f;
    int   o;
    e.fmt = 0; e.op = 0; e.ra = 0; e.rb = 0; e.imm = 0; e.due = 0;
    long_f = 0;
    if (w[15] == 1'b0) begin
      e.op = w[15:8]; e.ra = w[7:4]; e.rb = w[3:0];
      legal = (e.op >= 8'h01 && e.op <= 8'h15) || (e.op >= 8'h19 && e.op <= 8'h39);
      foreach (LONG_OPS[i]) if (LONG_OPS[i] == e.op) long_f = 1;
    end else if (w[14] == 1'b0) begin
      e.fmt = 1; e.op = {6'b0, w[13:12]}; e.ra = w[11:8]; e.imm = {8'h00, w[7:0]};
      legal = 1;
    end else begin
      e.fmt = 2; e.op = {4'b0, w[13:10]};
      o = int'(w[9:0]);
      if (o >= 512) o = o - 1024;
      o = o * 2;
      e.imm = o[15:0];
      legal = (w[13:10] < 4'd10);
    end
    e.len = long_f ? 3'd6 : 3'd2;
    e.ext = long_f ? x : 32'h0;
    e.bad = !legal;
    return e;
  endfunction

  task automatic send(input logic [15:0] w, input logic [31:0] x, input int gap);
    exp_t       e;
    logic [7:0] bs [6];
    int         n;
    e  = model(w, x);
    n  = int'(e.len);
    bs[0] = w[15:8];  bs[1] = w[7:0];
    bs[2] = x[31:24]; bs[3] = x[23:16]; bs[4] = x[15:8]; bs[5] = x[7:0];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 1'b1;
      byte_in  = bs[i];
      if (i == n - 1) begin
        e.due = cyc + 1;
        q.push_back(e);
      end
      for (int k = 0; k < gap; k++) begin
        @(negedge clk);
        byte_vld = 1'b0;
        byte_in  = 8'hEE;
      end
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (run) begin
      if (dec_vld) begin
        if (q.size() == 0) begin
          chk("R9", "unexpected pulse", 64'd1, 64'd0);
        end else begin
          exp_t e;
          string ft;
          e  = q.pop_front();
          ft = (e.fmt == 2'd0) ? "R4" : (e.fmt == 2'd1) ? "R5" : "R6";
          chk("R9", "pulse cycle", 64'(cyc), 64'(e.due));
          chk("R3", "format", 64'(dec_fmt), 64'(e.fmt));
          chk(ft, "opcode (R2 byte order)", 64'(dec_op), 64'(e.op));
          chk(ft, "reg a", 64'(dec_ra), 64'(e.ra));
          chk(ft, "reg b", 64'(dec_rb), 64'(e.rb));
          chk(ft, "immediate", 64'(dec_imm), 64'(e.imm));
          chk("R7", "length", 64'(dec_len), 64'(e.len));
          chk("R2", "extension", 64'(dec_ext), 64'(e.ext));
          chk("R8", "illegal flag", 64'(dec_bad), 64'(e.bad));
          last = e;
        end
      end else begin
        if (q.size() > 0 && q[0].due <= cyc) begin
          chk("R9", "missing pulse", 64'd0, 64'd1);
          void'(q.pop_front());
        end
        chk("R10", "held fields",
            {26'd0, dec_fmt, dec_op, dec_ra, dec_rb, dec_imm, dec_len, dec_bad},
            {26'd0, last.fmt, last.op, last.ra, last.rb, last.imm, last.len, last.bad});
        chk("R10", "held extension", 64'(dec_ext), 64'(last.ext));
      end
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog: actual hang expected completion");
    summary();
    $finish;
  end

  initial begin
    last.fmt = 0; last.op = 0; last.ra = 0; last.rb = 0; last.imm = 0;
    last.len = 0; last.ext = 0; last.bad = 0; last.due = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "valid after reset", 64'(dec_vld), 64'd0);
    chk("R1", "fields after reset",
        {dec_fmt, dec_op, dec_ra, dec_rb, dec_imm, dec_len, dec_bad}, 64'd0);
    chk("R1", "extension after reset", 64'(dec_ext), 64'd0);
    run = 1'b1;

    // Every first byte, mixed second bytes and occasional idle gaps (R9)
    for (int h = 0; h < 256; h++) begin
      logic [7:0] hb;
      logic [7:0] lb;
      hb = h[7:0];
      lb = 8'(h * 37 + 5);
      send({hb, lb}, {hb, ~hb, 8'h5A, hb ^ 8'hC3}, (h % 7 == 3) ? 2 : 0);
    end

    // Branch offset corners (R6) and illegal conditions (R8)
    send(16'hC3FF, 32'h0, 0);
    send(16'hC200, 32'h0, 1);
    send(16'hC1FF, 32'h0, 0);
    send(16'hE400, 32'h0, 0);
    send(16'hFC01, 32'h0, 0);
    send(16'hE801, 32'h0, 0);
    // Register-immediate corners (R5)
    send(16'hBFFF, 32'h0, 0);
    send(16'h8000, 32'h0, 0);
    send(16'h9A80, 32'h0, 3);
    // Long forms with gaps inside the extension (R2, R7, R9)
    send(16'h30FF, 32'hDEADBEEF, 1);
    send(16'h0112, 32'h01234567, 0);
    send(16'h3934, 32'h89ABCDEF, 2);
    // Illegal gap opcodes and limits (R8)
    send(16'h1611, 32'hFFFFFFFF, 0);
    send(16'h1822, 32'hFFFFFFFF, 0);
    send(16'h3A00, 32'hFFFFFFFF, 0);
    send(16'h7FFF, 32'hFFFFFFFF, 0);
    send(16'h0000, 32'hFFFFFFFF, 0);

    @(negedge clk);
    byte_vld = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9", "pending expectations", 64'(q.size()), 64'd0);
    summary();
    $finish;
  end
endmodule